// File: doc/BRIEF.md
# Address Translation Request Sequencer

This block steps one memory access at a time through address translation. A requester hands over a virtual address, an address-space tag and a security bit. The sequencer first asks the per-side micro TLB. If that misses, it asks the shared main TLB with the same three values. If both miss, it either issues a table-walk read or ends the access with a section translation fault. Which of these happens depends on the walk-disable bit that belongs to the selected translation base.

The base is chosen by a programmable split: base 0 serves addresses whose top N bits are all zero, and base 1 serves the rest. A split of zero always selects base 0. The inner-cacheability code of the chosen base decides where the walk read goes: to the L1 data cache or to external memory. A walk result is written into the main TLB for one cycle before the access reports completion. Results and faults are held on a valid/ready response port until the requester takes them.

Top module: `xlat_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it, `req_ready` is 1. In that same state `rsp_valid`, `micro_lookup_valid`, `main_lookup_valid`, `walk_rd_cache`, `walk_rd_mem` and `fill_valid` are all 0. A reset applied in the middle of a walk returns the block to this state.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `micro_lookup_valid` is 1, and `lookup_va`, `lookup_asid` and `lookup_ns` carry the captured request.
- R3: When `micro_hit` is high during the micro lookup cycle, the next cycle shows `rsp_valid`=1, `rsp_fault`=0 and `rsp_pa`=`micro_pa`. `main_lookup_valid` is never raised for that access, whatever `main_hit` is doing.
- R4: A micro miss leads, in the next cycle, to `main_lookup_valid`=1 with the same address, ASID and security bit. A main hit in that cycle leads, in the following cycle, to a response with `rsp_pa`=`main_pa` and no fault.
- R5: Base 1 is selected when `split_n` is nonzero and any of the top `split_n` bits of the virtual address is 1. Otherwise base 0 is selected. A `split_n` of 0 always selects base 0.
- R6: On a main miss where the selected base's disable bit (`walk_dis0` or `walk_dis1`) is 1, the next cycle shows `rsp_valid`=1, `rsp_fault`=1 and `rsp_pa`=0. No walk read is raised for that access.
- R7: On a main miss where the walk is enabled, the next cycle raises a walk read. The selected base's inner-cacheability code decides the target. Code 2'b01 (write-back, allocate) and code 2'b11 (write-back, no allocate) raise `walk_rd_cache`. Code 2'b00 (non-cacheable) and code 2'b10 (write-through) raise `walk_rd_mem`. `walk_rd_va` carries the request address.
- R8: The walk read stays raised, on the same target, until a cycle in which `walk_rsp_valid` is 1. The response may arrive any number of cycles after the read is raised.
- R9: The cycle after a walk response shows `fill_valid`=1, with `fill_va`, `fill_asid` and `fill_ns` from the request and `fill_pa` equal to the returned `walk_pa`. During that cycle `rsp_valid` is 0. The next cycle shows a response with `rsp_pa`=`walk_pa` and no fault.
- R10: `rsp_valid`, `rsp_pa` and `rsp_fault` hold steady until `rsp_ready` is 1. While a request is in progress or a response is pending, `req_ready` stays 0. It returns to 1 in the cycle after the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_va | input | 32 | Virtual address of the access |
| req_asid | input | 8 | Address-space tag of the access |
| req_ns | input | 1 | Security state of the access (1 = non-secure) |
| split_n | input | 3 | Number of top address bits that choose between base 0 and base 1 |
| walk_dis0 | input | 1 | Walk disable for base 0 |
| walk_dis1 | input | 1 | Walk disable for base 1 |
| icache_code0 | input | 2 | Inner-cacheability code of base 0 |
| icache_code1 | input | 2 | Inner-cacheability code of base 1 |
| lookup_va | output | 32 | Address presented to the micro and main TLB |
| lookup_asid | output | 8 | ASID presented to the TLBs |
| lookup_ns | output | 1 | Security bit presented to the TLBs |
| micro_lookup_valid | output | 1 | Micro TLB lookup cycle |
| micro_hit | input | 1 | Micro TLB hit during its lookup cycle |
| micro_pa | input | 32 | Physical address from the micro TLB |
| main_lookup_valid | output | 1 | Main TLB lookup cycle |
| main_hit | input | 1 | Main TLB hit during its lookup cycle |
| main_pa | input | 32 | Physical address from the main TLB |
| walk_rd_cache | output | 1 | Walk read directed at the L1 data cache |
| walk_rd_mem | output | 1 | Walk read directed at external memory |
| walk_rd_va | output | 32 | Address being walked |
| walk_rsp_valid | input | 1 | Walk read has returned |
| walk_pa | input | 32 | Physical address produced by the walk |
| fill_valid | output | 1 | Write the walk result into the main TLB |
| fill_va | output | 32 | Virtual address of the new entry |
| fill_asid | output | 8 | ASID of the new entry |
| fill_ns | output | 1 | Security bit of the new entry |
| fill_pa | output | 32 | Physical address of the new entry |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pa | output | 32 | Translated address (0 on fault) |
| rsp_fault | output | 1 | Section translation fault |

## Verification
A state register in the wrong place shows up at the ports within one cycle of the decision that should have been made. Some examples: a lookup strobe on the wrong side, a walk read after a fault, a fill without a walk response, or a response whose address or fault flag differs from the source the path calls for. A mis-selected base or a swapped cacheability test gives a walk read on the wrong target, or a fault where a read was due, one cycle after the main miss. A lost hold shows as a response that drops or changes while `rsp_ready` is low. The checks therefore sample every strobe in each cycle of every path. They compare addresses against the source that each path names.

// File: rtl/xlat_seq_pkg.sv
package xlat_seq_pkg;

    localparam int VA_W    = 32;
    localparam int PA_W    = 32;
    localparam int ASID_W  = 8;
    localparam int SPLIT_W = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MICRO,
        S_MAIN,
        S_WALK,
        S_REFILL,
        S_DONE,
        S_FAULT
    } xlat_state_e;

    typedef enum logic [1:0] {
        IC_NONCACHE = 2'b00,
        IC_WB_ALLOC = 2'b01,
        IC_WTHRU    = 2'b10,
        IC_WB_NOALC = 2'b11
    } inner_cache_e;

    typedef struct packed {
        logic [VA_W-1:0]   va;
        logic [ASID_W-1:0] asid;
        logic              ns;
    } xlat_req_t;

    // Base 1 serves any address with a set bit among its top `split` bits.
    function automatic logic pick_base1(logic [VA_W-1:0] va, logic [SPLIT_W-1:0] split);
        logic [VA_W-1:0] upper;
        if (split == '0) return 1'b0;
        upper = va >> (VA_W - int'(split));
        return upper != '0;
    endfunction

    // Both write-back codes have bit 0 set.
    function automatic logic routes_to_cache(inner_cache_e code);
        return (code == IC_WB_ALLOC) || (code == IC_WB_NOALC);
    endfunction

endpackage

// File: rtl/xlat_req_reg.sv
module xlat_req_reg
    import xlat_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  xlat_req_t req_in,
    output xlat_req_t req_q
);

    always_ff @(posedge clk) begin
        if (rst)       req_q <= '0;
        else if (load) req_q <= req_in;
    end

    // Captured request must not move while an access is in flight.
    assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(req_q));

endmodule

// File: rtl/xlat_walk_policy.sv
module xlat_walk_policy
    import xlat_seq_pkg::*;
(
    input  logic [VA_W-1:0]    va,
    input  logic [SPLIT_W-1:0] split_n,
    input  logic               walk_dis0,
    input  logic               walk_dis1,
    input  logic [1:0]         icache_code0,
    input  logic [1:0]         icache_code1,
    output logic               walk_allowed,
    output logic               route_cache
);

    logic         base1;
    inner_cache_e code_sel;

    always_comb begin
        base1        = pick_base1(va, split_n);
        walk_allowed = base1 ? !walk_dis1 : !walk_dis0;
        code_sel     = inner_cache_e'(base1 ? icache_code1 : icache_code0);
        route_cache  = routes_to_cache(code_sel);
    end

endmodule

// File: rtl/xlat_fsm.sv
module xlat_fsm
    import xlat_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            micro_hit,
    input  logic [PA_W-1:0] micro_pa,
    input  logic            main_hit,
    input  logic [PA_W-1:0] main_pa,
    input  logic            walk_allowed,
    input  logic            route_cache,
    input  logic            walk_rsp_valid,
    input  logic [PA_W-1:0] walk_pa,
    input  logic            rsp_ready,
    output logic            load,
    output logic            req_ready,
    output logic            micro_lookup_valid,
    output logic            main_lookup_valid,
    output logic            walk_rd_cache,
    output logic            walk_rd_mem,
    output logic            fill_valid,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [PA_W-1:0] pa_q
);

    xlat_state_e state;
    logic        route_q;
    logic        walk_rd_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            pa_q    <= '0;
            route_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE:   if (req_valid) state <= S_MICRO;
                S_MICRO: begin
                    if (micro_hit) begin
                        pa_q  <= micro_pa;
                        state <= S_DONE;
                    end else begin
                        state <= S_MAIN;
                    end
                end
                S_MAIN: begin
                    if (main_hit) begin
                        pa_q  <= main_pa;
                        state <= S_DONE;
                    end else if (!walk_allowed) begin
                        pa_q  <= '0;
                        state <= S_FAULT;
                    end else begin
                        route_q <= route_cache;
                        state   <= S_WALK;
                    end
                end
                S_WALK: begin
                    if (walk_rsp_valid) begin
                        pa_q  <= walk_pa;
                        state <= S_REFILL;
                    end
                end
                S_REFILL: state <= S_DONE;
                S_DONE, S_FAULT: if (rsp_ready) state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready          = (state == S_IDLE);
        load               = req_ready && req_valid;
        micro_lookup_valid = (state == S_MICRO);
        main_lookup_valid  = (state == S_MAIN);
        walk_rd_valid      = (state == S_WALK);
        walk_rd_cache      = walk_rd_valid && route_q;
        walk_rd_mem        = walk_rd_valid && !route_q;
        fill_valid         = (state == S_REFILL);
        rsp_valid          = (state == S_DONE) || (state == S_FAULT);
        rsp_fault          = (state == S_FAULT);
    end

    assert_micro_hit_done_R3: assert property (@(posedge clk) disable iff (rst)
        micro_lookup_valid && micro_hit |=> rsp_valid && !rsp_fault && !main_lookup_valid);

    assert_micro_miss_main_R4: assert property (@(posedge clk) disable iff (rst)
        micro_lookup_valid && !micro_hit |=> main_lookup_valid);

    assert_fault_no_walk_R6: assert property (@(posedge clk) disable iff (rst)
        main_lookup_valid && !main_hit && !walk_allowed |=> rsp_fault && !walk_rd_cache && !walk_rd_mem);

    assert_walk_wait_R8: assert property (@(posedge clk) disable iff (rst)
        walk_rd_valid && !walk_rsp_valid |=> walk_rd_valid && $stable(walk_rd_cache));

    assert_fill_then_done_R9: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> rsp_valid && !rsp_fault && $stable(pa_q));

    assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(pa_q) && $stable(rsp_fault));

endmodule

// File: rtl/xlat_sequencer.sv
module xlat_sequencer
    import xlat_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_va,
    input  logic [ASID_W-1:0]  req_asid,
    input  logic               req_ns,
    input  logic [SPLIT_W-1:0] split_n,
    input  logic               walk_dis0,
    input  logic               walk_dis1,
    input  logic [1:0]         icache_code0,
    input  logic [1:0]         icache_code1,
    output logic [VA_W-1:0]    lookup_va,
    output logic [ASID_W-1:0]  lookup_asid,
    output logic               lookup_ns,
    output logic               micro_lookup_valid,
    input  logic               micro_hit,
    input  logic [PA_W-1:0]    micro_pa,
    output logic               main_lookup_valid,
    input  logic               main_hit,
    input  logic [PA_W-1:0]    main_pa,
    output logic               walk_rd_cache,
    output logic               walk_rd_mem,
    output logic [VA_W-1:0]    walk_rd_va,
    input  logic               walk_rsp_valid,
    input  logic [PA_W-1:0]    walk_pa,
    output logic               fill_valid,
    output logic [VA_W-1:0]    fill_va,
    output logic [ASID_W-1:0]  fill_asid,
    output logic               fill_ns,
    output logic [PA_W-1:0]    fill_pa,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PA_W-1:0]    rsp_pa,
    output logic               rsp_fault
);

    xlat_req_t       req_in;
    xlat_req_t       req_q;
    logic            load;
    logic            walk_allowed;
    logic            route_cache;
    logic [PA_W-1:0] pa_q;

    assign req_in = '{va: req_va, asid: req_asid, ns: req_ns};

    xlat_req_reg u_req (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .req_in (req_in),
        .req_q  (req_q)
    );

    xlat_walk_policy u_policy (
        .va           (req_q.va),
        .split_n      (split_n),
        .walk_dis0    (walk_dis0),
        .walk_dis1    (walk_dis1),
        .icache_code0 (icache_code0),
        .icache_code1 (icache_code1),
        .walk_allowed (walk_allowed),
        .route_cache  (route_cache)
    );

    xlat_fsm u_fsm (
        .clk                (clk),
        .rst                (rst),
        .req_valid          (req_valid),
        .micro_hit          (micro_hit),
        .micro_pa           (micro_pa),
        .main_hit           (main_hit),
        .main_pa            (main_pa),
        .walk_allowed       (walk_allowed),
        .route_cache        (route_cache),
        .walk_rsp_valid     (walk_rsp_valid),
        .walk_pa            (walk_pa),
        .rsp_ready          (rsp_ready),
        .load               (load),
        .req_ready          (req_ready),
        .micro_lookup_valid (micro_lookup_valid),
        .main_lookup_valid  (main_lookup_valid),
        .walk_rd_cache      (walk_rd_cache),
        .walk_rd_mem        (walk_rd_mem),
        .fill_valid         (fill_valid),
        .rsp_valid          (rsp_valid),
        .rsp_fault          (rsp_fault),
        .pa_q               (pa_q)
    );

    always_comb begin
        lookup_va   = req_q.va;
        lookup_asid = req_q.asid;
        lookup_ns   = req_q.ns;
        walk_rd_va  = req_q.va;
        fill_va     = req_q.va;
        fill_asid   = req_q.asid;
        fill_ns     = req_q.ns;
        fill_pa     = pa_q;
        rsp_pa      = pa_q;
    end

endmodule

// File: tb/tb_xlat_sequencer.sv
module tb_xlat_sequencer;

    localparam int CLK_P = 10;
    localparam int NVEC  = 13;

    // kind: 0 micro hit, 1 main hit, 2 walk to cache, 3 walk to memory, 4 fault
    typedef struct packed {
        logic [31:0] va;
        logic [2:0]  split;
        logic        dis0;
        logic        dis1;
        logic [1:0]  ic0;
        logic [1:0]  ic1;
        logic        uhit;
        logic        mhit;
        logic [3:0]  lat;
        logic [2:0]  kind;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'h1000_0000, 3'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 4'd0, 3'd0},
        '{32'h2345_6000, 3'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 4'd0, 3'd1},
        '{32'h0010_0000, 3'd0, 1'b0, 1'b1, 2'b01, 2'b00, 1'b0, 1'b0, 4'd0, 3'd2},
        '{32'h0020_0000, 3'd0, 1'b0, 1'b1, 2'b11, 2'b00, 1'b0, 1'b0, 4'd3, 3'd2},
        '{32'h0030_0000, 3'd0, 1'b0, 1'b1, 2'b00, 2'b01, 1'b0, 1'b0, 4'd1, 3'd3},
        '{32'h0040_0000, 3'd0, 1'b0, 1'b1, 2'b10, 2'b01, 1'b0, 1'b0, 4'd5, 3'd3},
        '{32'h8000_0000, 3'd0, 1'b1, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 4'd0, 3'd4},
        '{32'h8000_0000, 3'd1, 1'b1, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 4'd2, 3'd3},
        '{32'h7FFF_F000, 3'd1, 1'b1, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 4'd0, 3'd4},
        '{32'h1000_0000, 3'd3, 1'b0, 1'b1, 2'b01, 2'b00, 1'b0, 1'b0, 4'd1, 3'd2},
        '{32'h2000_0000, 3'd3, 1'b0, 1'b1, 2'b01, 2'b01, 1'b0, 1'b0, 4'd0, 3'd4},
        '{32'h0100_0000, 3'd7, 1'b0, 1'b1, 2'b10, 2'b01, 1'b0, 1'b0, 4'd0, 3'd3},
        '{32'h0ABC_0000, 3'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 4'd0, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [7:0]  req_asid = '0;
    logic        req_ns = 1'b0;
    logic [2:0]  split_n = '0;
    logic        walk_dis0 = 1'b0;
    logic        walk_dis1 = 1'b0;
    logic [1:0]  icache_code0 = '0;
    logic [1:0]  icache_code1 = '0;
    logic [31:0] lookup_va;
    logic [7:0]  lookup_asid;
    logic        lookup_ns;
    logic        micro_lookup_valid;
    logic        micro_hit = 1'b0;
    logic [31:0] micro_pa = '0;
    logic        main_lookup_valid;
    logic        main_hit = 1'b0;
    logic [31:0] main_pa = '0;
    logic        walk_rd_cache;
    logic        walk_rd_mem;
    logic [31:0] walk_rd_va;
    logic        walk_rsp_valid = 1'b0;
    logic [31:0] walk_pa = '0;
    logic        fill_valid;
    logic [31:0] fill_va;
    logic [7:0]  fill_asid;
    logic        fill_ns;
    logic [31:0] fill_pa;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_pa;
    logic        rsp_fault;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    xlat_sequencer dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [31:0] exp_pa;
        logic [7:0]  asid;
        logic        ns;
        asid = 8'(idx * 17 + 3);
        ns   = idx[0];
        split_n = v.split; walk_dis0 = v.dis0; walk_dis1 = v.dis1;
        icache_code0 = v.ic0; icache_code1 = v.ic1;
        req_va = v.va; req_asid = asid; req_ns = ns; req_valid = 1'b1;
        #1 chk("R2 req_ready when idle", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 micro lookup strobe", 32'(micro_lookup_valid), 32'd1);
        chk("R2 lookup va", lookup_va, v.va);
        chk("R2 lookup asid/ns", {23'd0, lookup_asid, lookup_ns}, {23'd0, asid, ns});
        chk("R10 req_ready low while busy", 32'(req_ready), 32'd0);
        micro_hit = v.uhit; micro_pa = v.va ^ 32'hA5A5_0000;
        main_hit  = v.mhit; main_pa  = v.va ^ 32'h5A5A_0000;
        @(negedge clk);
        micro_hit = 1'b0;
        if (v.kind == 3'd0) begin
            exp_pa = v.va ^ 32'hA5A5_0000;
            chk("R3 micro hit response", {rsp_valid, rsp_fault, main_lookup_valid}, 32'b100);
            chk("R3 micro pa", rsp_pa, exp_pa);
            main_hit = 1'b0;
        end else begin
            chk("R4 main lookup after micro miss", 32'(main_lookup_valid), 32'd1);
            chk("R4 main lookup va", lookup_va, v.va);
            @(negedge clk);
            main_hit = 1'b0;
            if (v.kind == 3'd1) begin
                exp_pa = v.va ^ 32'h5A5A_0000;
                chk("R4 main hit response", {rsp_valid, rsp_fault}, 32'b10);
                chk("R4 main pa", rsp_pa, exp_pa);
            end else if (v.kind == 3'd4) begin
                exp_pa = '0;
                chk("R6 fault response", {rsp_valid, rsp_fault, walk_rd_cache, walk_rd_mem}, 32'b1100);
                chk("R6 fault pa", rsp_pa, 32'd0);
            end else begin
                exp_pa = v.va ^ 32'h0F0F_0000;
                chk("R5 R7 walk target", {walk_rd_cache, walk_rd_mem},
                    (v.kind == 3'd2) ? 32'b10 : 32'b01);
                chk("R7 walk va", walk_rd_va, v.va);
                for (int c = 0; c < int'(v.lat); c++) begin
                    @(negedge clk);
                    chk("R8 walk read held", {walk_rd_cache, walk_rd_mem, fill_valid},
                        (v.kind == 3'd2) ? 32'b100 : 32'b010);
                end
                walk_rsp_valid = 1'b1; walk_pa = exp_pa;
                @(negedge clk);
                walk_rsp_valid = 1'b0;
                chk("R9 fill strobe", {fill_valid, rsp_valid, walk_rd_cache, walk_rd_mem}, 32'b1000);
                chk("R9 fill pa", fill_pa, exp_pa);
                chk("R9 fill tag", {fill_va[23:0], fill_asid}, {v.va[23:0], asid});
                chk("R9 fill ns", 32'(fill_ns), 32'(ns));
                @(negedge clk);
                chk("R9 response after fill", {rsp_valid, rsp_fault, fill_valid}, 32'b100);
                chk("R9 walk pa", rsp_pa, exp_pa);
            end
        end
        @(negedge clk);
        chk("R10 response held", {req_ready, rsp_valid, rsp_fault}, {30'd0, 1'b1, v.kind == 3'd4});
        chk("R10 pa held", rsp_pa, exp_pa);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R10 idle after accept", {req_ready, rsp_valid}, 32'b10);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 reset outputs", {req_ready, rsp_valid, micro_lookup_valid, main_lookup_valid,
                                 walk_rd_cache, walk_rd_mem, fill_valid}, 32'b1000000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", {req_ready, rsp_valid, micro_lookup_valid}, 32'b100);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

        // Reset in the middle of a walk
        split_n = 3'd0; walk_dis0 = 1'b0; icache_code0 = 2'b01;
        req_va = 32'h0055_0000; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 walk started before reset", 32'(walk_rd_cache), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset aborts walk", {req_ready, walk_rd_cache, walk_rd_mem, fill_valid, rsp_valid},
            32'b10000);

        // Requests offered while a response waits are not taken
        req_va = 32'h0066_0000; req_valid = 1'b1;
        @(negedge clk);
        micro_hit = 1'b1; micro_pa = 32'h1234_5000;
        @(negedge clk);
        micro_hit = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 no new lookup while response pending", {rsp_valid, micro_lookup_valid, req_ready},
            32'b100);
        chk("R10 pending pa intact", rsp_pa, 32'h1234_5000);
        req_valid = 1'b0; rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R10 idle after pending response", 32'(req_ready), 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule